// File: doc/BRIEF.md
# Fixed-Point ALU with Arithmetic and Sticky Status

This block is a 32-bit integer arithmetic/logic unit for a signal-processing datapath. On each clock edge where an operation is offered it takes two register operands and a 3-bit function code. The functions are add, subtract, compare, bitwise AND/OR/XOR and pass. It writes a registered result and a per-operation status word holding the zero, negative, overflow, carry and invalid flags. A second register keeps the overflow and carry events. That register holds them until software clears it with a synchronous strobe.

A mode input selects saturating arithmetic. In that mode a signed overflow of add or subtract clamps the written value to the largest positive or the most negative number instead of wrapping.

A 4-bit condition selector is decoded against the stored status word. It gives a single true/false output that a sequencer can use to predicate the instruction that follows the operation.

Top module: `fxalu_core`

## Requirements
- R1: Add (code 0) and subtract (code 1, A minus B) are sampled on a rising edge with `op_valid`=1, and their result and flags appear after that edge. The status bit positions are: bit0 zero, bit1 negative, bit2 overflow (signed two's-complement), bit3 carry, bit4 invalid. Zero and negative describe the unclamped 32-bit sum. For subtract, carry=1 means no unsigned borrow. Invalid is always written 0.
- R2: Adding 0xFFFFFFFF and 0x00000001 yields 0 with zero=1, negative=0, overflow=0, carry=1, invalid=0, and leaves the sticky overflow bit clear.
- R3: With `sat_en`=1, an add or subtract that overflows writes 0x7FFFFFFF when the true sum is positive and 0x80000000 when it is negative. The overflow flag is still set, and zero, negative and carry still describe the unclamped sum.
- R4: With `sat_en`=0, an overflowing add or subtract writes the wrapped 32-bit sum.
- R5: Compare (code 2) sets all flags exactly as subtract would, but leaves `result` unchanged.
- R6: AND (3), OR (4), XOR (5) and pass-A (6) write their result, clear overflow and carry, and set zero and negative from the written value.
- R7: Code 7, or `op_valid`=0, changes neither `result`, `status` nor the sticky word.
- R8: `sticky` bit0 is set by any operation that reports overflow, and bit1 by any that reports carry. Both bits then hold through later operations that do not report the event.
- R9: `sticky_clr`=1 clears the sticky word on that edge. An operation sampled on the same edge still ORs its own overflow and carry into the cleared word.
- R10: `cond_true` reflects the stored status for `cond_sel` codes as follows. 0 EQ (zero). 1 NE. 2 LT (negative XOR overflow). 3 GE. 4 LE (zero, or LT). 5 GT. 6 overflow set. 7 overflow clear. 8 carry set. 9 carry clear. 10 always true. Codes 11 to 15 are always false.
- R11: After reset, `result`, `status` and `sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 3 | Function code (see R1, R5, R6, R7) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sat_en | input | 1 | Saturating arithmetic mode |
| sticky_clr | input | 1 | Synchronous clear of the sticky word |
| cond_sel | input | 4 | Condition code to evaluate |
| result | output | 32 | Registered result |
| status | output | 5 | Per-operation flags {invalid, carry, overflow, negative, zero} |
| sticky | output | 2 | Accumulated {carry, overflow} events |
| cond_true | output | 1 | Selected condition holds on stored flags |

## Verification
The sticky clear and a flag-raising operation can land on the same clock edge. The block must then start the sticky word afresh, but must not drop the new event. The bench provokes this directly: it sets the sticky word, then offers an overflowing add together with `sticky_clr`, and also a carry-only subtract together with the clear. It expects exactly the new operation's bits to remain. Random stimulus also asserts the clear in about one cycle in eight, independent of the operation. A reference model in the bench judges every outcome by restating the R9 merge rule.

// File: rtl/fxalu_pkg.sv
`timescale 1ns/1ps
package fxalu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_CMP  = 3'd2,
    OP_AND  = 3'd3,
    OP_OR   = 3'd4,
    OP_XOR  = 3'd5,
    OP_PASS = 3'd6,
    OP_NOP  = 3'd7
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_LT  = 4'd2,
    CC_GE  = 4'd3,
    CC_LE  = 4'd4,
    CC_GT  = 4'd5,
    CC_VS  = 4'd6,
    CC_VC  = 4'd7,
    CC_CS  = 4'd8,
    CC_CC  = 4'd9,
    CC_TRU = 4'd10
  } cond_e;

  // status word bit positions
  localparam int unsigned ST_Z = 0;
  localparam int unsigned ST_N = 1;
  localparam int unsigned ST_V = 2;
  localparam int unsigned ST_C = 3;
  localparam int unsigned ST_I = 4;
  localparam int unsigned ST_W = 5;

  // sticky word bit positions
  localparam int unsigned SK_V = 0;
  localparam int unsigned SK_C = 1;
  localparam int unsigned SK_W = 2;

endpackage

// File: rtl/fxalu_datapath.sv
`timescale 1ns/1ps
module fxalu_datapath
  import fxalu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [2:0]      op,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic            sat,
  output logic [DW-1:0]   res,
  output logic            res_wr,
  output logic [ST_W-1:0] flags,
  output logic            ovf_evt
);

  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MAXNEG = {1'b1, {(DW-1){1'b0}}};

  // returns {overflow, carry, raw[DW-1:0]}
  function automatic logic [DW+1:0] addsub(input logic [DW-1:0] x,
                                           input logic [DW-1:0] y,
                                           input logic          sub);
    logic [DW-1:0] ye;
    logic [DW:0]   s;
    logic          v;
    ye = sub ? ~y : y;
    s  = {1'b0, x} + {1'b0, ye} + {{DW{1'b0}}, sub};
    v  = (x[DW-1] == ye[DW-1]) && (s[DW-1] != x[DW-1]);
    return {v, s[DW], s[DW-1:0]};
  endfunction

  function automatic logic [DW-1:0] clamp(input logic [DW-1:0] raw,
                                          input logic          v,
                                          input logic          en,
                                          input logic          sgn);
    if (en && v) return sgn ? MAXNEG : MAXPOS;
    return raw;
  endfunction

  logic [DW+1:0] as_out;
  logic          is_sub;
  logic [DW-1:0] raw;
  logic          v_bit;
  logic          c_bit;

  assign is_sub = (op == OP_SUB) || (op == OP_CMP);
  assign as_out = addsub(a, b, is_sub);
  assign raw    = as_out[DW-1:0];
  assign c_bit  = as_out[DW];
  assign v_bit  = as_out[DW+1];

  always_comb begin
    res    = '0;
    res_wr = 1'b0;
    flags  = '0;
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        res       = clamp(raw, v_bit, sat, a[DW-1]);
        res_wr    = (op != OP_CMP);
        flags[ST_Z] = (raw == '0);
        flags[ST_N] = raw[DW-1];
        flags[ST_V] = v_bit;
        flags[ST_C] = c_bit;
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS: begin
        case (op)
          OP_AND:  res = a & b;
          OP_OR:   res = a | b;
          OP_XOR:  res = a ^ b;
          default: res = a;
        endcase
        res_wr      = 1'b1;
        flags[ST_Z] = (res == '0);
        flags[ST_N] = res[DW-1];
      end
      default: begin
        res    = '0;
        res_wr = 1'b0;
      end
    endcase
  end

  assign ovf_evt = flags[ST_V];

endmodule

// File: rtl/fxalu_statreg.sv
`timescale 1ns/1ps
module fxalu_statreg
  import fxalu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd,
  input  logic            res_wr,
  input  logic [DW-1:0]   new_res,
  input  logic [ST_W-1:0] new_flags,
  input  logic            clr,
  output logic [DW-1:0]   res_q,
  output logic [ST_W-1:0] st_q,
  output logic [SK_W-1:0] sk_q
);

  logic [SK_W-1:0] sk_evt;
  logic [SK_W-1:0] sk_base;

  assign sk_evt[SK_V] = upd && new_flags[ST_V];
  assign sk_evt[SK_C] = upd && new_flags[ST_C];
  assign sk_base      = clr ? '0 : sk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      st_q  <= '0;
      sk_q  <= '0;
    end else begin
      if (upd && res_wr) res_q <= new_res;
      if (upd)           st_q  <= new_flags;
      sk_q <= sk_base | sk_evt;
    end
  end

endmodule

// File: rtl/fxalu_condeval.sv
`timescale 1ns/1ps
module fxalu_condeval
  import fxalu_pkg::*;
(
  input  logic [3:0]      sel,
  input  logic [ST_W-1:0] st,
  output logic            hit
);

  logic lt;
  assign lt = st[ST_N] ^ st[ST_V];

  always_comb begin
    case (sel)
      CC_EQ:   hit = st[ST_Z];
      CC_NE:   hit = !st[ST_Z];
      CC_LT:   hit = lt;
      CC_GE:   hit = !lt;
      CC_LE:   hit = st[ST_Z] || lt;
      CC_GT:   hit = !st[ST_Z] && !lt;
      CC_VS:   hit = st[ST_V];
      CC_VC:   hit = !st[ST_V];
      CC_CS:   hit = st[ST_C];
      CC_CC:   hit = !st[ST_C];
      CC_TRU:  hit = 1'b1;
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fxalu_core.sv
`timescale 1ns/1ps
module fxalu_core
  import fxalu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [DW-1:0]   opnd_a,
  input  logic [DW-1:0]   opnd_b,
  input  logic            sat_en,
  input  logic            sticky_clr,
  input  logic [3:0]      cond_sel,
  output logic [DW-1:0]   result,
  output logic [ST_W-1:0] status,
  output logic [SK_W-1:0] sticky,
  output logic            cond_true
);

  logic [DW-1:0]   dp_res;
  logic            dp_wr;
  logic [ST_W-1:0] dp_flags;
  logic            ovf_evt;
  logic            op_fire;

  assign op_fire = op_valid && (op_code != OP_NOP);

  fxalu_datapath #(.DW(DW)) u_dp (
    .op      (op_code),
    .a       (opnd_a),
    .b       (opnd_b),
    .sat     (sat_en),
    .res     (dp_res),
    .res_wr  (dp_wr),
    .flags   (dp_flags),
    .ovf_evt (ovf_evt)
  );

  fxalu_statreg #(.DW(DW)) u_sr (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (op_fire),
    .res_wr    (dp_wr),
    .new_res   (dp_res),
    .new_flags (dp_flags),
    .clr       (sticky_clr),
    .res_q     (result),
    .st_q      (status),
    .sk_q      (sticky)
  );

  fxalu_condeval u_ce (
    .sel (cond_sel),
    .st  (status),
    .hit (cond_true)
  );

endmodule

// File: rtl/fxalu_chk.sv
`timescale 1ns/1ps
module fxalu_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic          sat_en,
  input logic          sticky_clr,
  input logic [3:0]    cond_sel,
  input logic [DW-1:0] result,
  input logic [4:0]    status,
  input logic [1:0]    sticky,
  input logic          cond_true,
  input logic          ovf_evt
);

  localparam logic [DW-1:0] MAXPOS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MAXNEG = {1'b1, {(DW-1){1'b0}}};

  logic arith_op;
  logic logic_op;
  assign arith_op = (op_code == 3'd0) || (op_code == 3'd1);
  assign logic_op = (op_code >= 3'd3) && (op_code <= 3'd6);

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code == 3'd7) |=> ($stable(result) && $stable(status)));

  a_r5_cmp_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd2) |=> $stable(result));

  a_r6_logic_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && logic_op) |=> (!status[2] && !status[3]));

  a_r3_sat_clamps: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && arith_op && sat_en && ovf_evt)
      |=> ((result == MAXPOS || result == MAXNEG) && status[2]));

  a_r8_sticky_catches_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 3'd7 && ovf_evt) |=> sticky[0]);

  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!sticky_clr && !(op_valid && op_code != 3'd7)) |=> $stable(sticky));

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_clr && !op_valid) |=> (sticky == 2'b00));

  a_r10_true_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == 4'd10) |-> cond_true);

  a_r10_false_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel >= 4'd11) |-> !cond_true);

  a_r1_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code != 3'd7) |=> !status[4]);

endmodule

bind fxalu_core fxalu_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .sat_en     (sat_en),
  .sticky_clr (sticky_clr),
  .cond_sel   (cond_sel),
  .result     (result),
  .status     (status),
  .sticky     (sticky),
  .cond_true  (cond_true),
  .ovf_evt    (ovf_evt)
);

// File: tb/test_fxalu_core.sv
`timescale 1ns/1ps
module test_fxalu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd7;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        sat_en = 1'b0;
  logic        sticky_clr = 1'b0;
  logic [3:0]  cond_sel = 4'd0;
  logic [31:0] result;
  logic [4:0]  status;
  logic [1:0]  sticky;
  logic        cond_true;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] e_res = '0;
  logic [4:0]  e_st = '0;
  logic [1:0]  e_sk = '0;

  always #2.5 clk = ~clk;

  fxalu_core i_fxalu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_en(sat_en),
    .sticky_clr(sticky_clr), .cond_sel(cond_sel), .result(result),
    .status(status), .sticky(sticky), .cond_true(cond_true)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic void model(input logic v, input logic [2:0] op,
                                input logic [31:0] a, input logic [31:0] b,
                                input logic sat, input logic clr);
    longint sa, sb, t;
    logic ov, cy, neg, zer;
    logic [31:0] w;
    logic [1:0] ev;
    ev = 2'b00;
    if (v && op != 3'd7) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      if (op <= 3'd2) begin
        t  = (op == 3'd0) ? sa + sb : sa - sb;
        ov = (t > 64'sd2147483647) || (t < -64'sd2147483648);
        w  = t[31:0];
        cy = (op == 3'd0) ? ((64'(a) + 64'(b)) > 64'hFFFF_FFFF) : (a >= b);
        zer = (w == 0);
        neg = w[31];
        if (sat && ov) w = (t < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        if (op != 3'd2) e_res = w;
      end else begin
        case (op)
          3'd3: w = a & b;
          3'd4: w = a | b;
          3'd5: w = a ^ b;
          default: w = a;
        endcase
        ov = 0; cy = 0; zer = (w == 0); neg = w[31];
        e_res = w;
      end
      e_st = {1'b0, cy, ov, neg, zer};
      ev = {cy, ov};
    end
    e_sk = (clr ? 2'b00 : e_sk) | ev;
  endfunction

  function automatic logic cond_model(input logic [3:0] c, input logic [4:0] s);
    logic z, n, v, k, less;
    z = s[0]; n = s[1]; v = s[2]; k = s[3];
    less = (n != v);
    case (c)
      4'd0: return z;
      4'd1: return !z;
      4'd2: return less;
      4'd3: return !less;
      4'd4: return z | less;
      4'd5: return !z & !less;
      4'd6: return v;
      4'd7: return !v;
      4'd8: return k;
      4'd9: return !k;
      4'd10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input string req, input logic v, input logic [2:0] op,
                      input logic [31:0] a, input logic [31:0] b,
                      input logic sat, input logic clr, input logic [3:0] cs);
    @(negedge clk);
    op_valid = v; op_code = op; opnd_a = a; opnd_b = b;
    sat_en = sat; sticky_clr = clr; cond_sel = cs;
    @(posedge clk);
    #1;
    model(v, op, a, b, sat, clr);
    check({req, " result"}, result, e_res);
    check({req, " status"}, {27'd0, status}, {27'd0, e_st});
    check({req, " sticky"}, {30'd0, sticky}, {30'd0, e_sk});
    check({req, " cond"}, {31'd0, cond_true}, {31'd0, cond_model(cs, e_st)});
    @(negedge clk);
    op_valid = 1'b0; sticky_clr = 1'b0;
  endtask

  function automatic logic [31:0] pick_opnd();
    case ($urandom_range(0, 5))
      0: return 32'h7FFF_FFFF;
      1: return 32'h8000_0000;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 result", result, 32'd0);
    check("R11 status", {27'd0, status}, 32'd0);
    check("R11 sticky", {30'd0, sticky}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R2 -1 + 1
    step("R2", 1, 3'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 4'd0);
    check("R2 flags", {27'd0, status}, 32'b01001);
    check("R2 sticky_ov", {31'd0, sticky[0]}, 32'd0);
    // R1 plain subtract with borrow
    step("R1", 1, 3'd1, 32'd3, 32'd5, 0, 0, 4'd2);
    // R4 wrap
    step("R4", 1, 3'd0, 32'h7FFF_FFFF, 32'd1, 0, 0, 4'd6);
    check("R4 wrapped", result, 32'h8000_0000);
    // R3 saturation both directions
    step("R3", 1, 3'd0, 32'h7FFF_FFFF, 32'd1, 1, 0, 4'd3);
    check("R3 maxpos", result, 32'h7FFF_FFFF);
    step("R3", 1, 3'd1, 32'h8000_0000, 32'd1, 1, 0, 4'd2);
    check("R3 maxneg", result, 32'h8000_0000);
    // R5 compare keeps result, GE
    step("R5", 1, 3'd2, 32'd9, 32'd9, 0, 0, 4'd3);
    check("R5 kept", result, 32'h8000_0000);
    // R6 logic ops
    step("R6", 1, 3'd3, 32'hF0F0_0000, 32'h0F0F_0000, 0, 0, 4'd0);
    step("R6", 1, 3'd6, 32'h8000_0001, 32'd0, 0, 0, 4'd2);
    // R7 nop and idle
    step("R7", 1, 3'd7, 32'h1234_5678, 32'h1, 1, 0, 4'd1);
    step("R7", 0, 3'd0, 32'h7FFF_FFFF, 32'h1, 0, 0, 4'd6);
    // R8 sticky holds (set earlier)
    check("R8 held", {30'd0, sticky}, 32'b11);
    // R9 clear alone, then clear with same-cycle events
    step("R9", 0, 3'd0, 32'd0, 32'd0, 0, 1, 4'd10);
    check("R9 cleared", {30'd0, sticky}, 32'd0);
    step("R8", 1, 3'd0, 32'h8000_0000, 32'h8000_0000, 0, 0, 4'd0);
    step("R9", 1, 3'd0, 32'h4000_0000, 32'h4000_0000, 0, 1, 4'd6);
    check("R9 ov kept", {30'd0, sticky}, 32'b01);
    step("R9", 1, 3'd1, 32'd7, 32'd2, 0, 1, 4'd8);
    check("R9 carry kept", {30'd0, sticky}, 32'b10);
    // R10 every code
    for (int c = 0; c < 16; c++)
      step("R10", 1, 3'd1, 32'hFFFF_FFF0, 32'd5, 0, 0, 4'(c));

    // random mix, R1 R3 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < 600; i++) begin
      step("RND", ($urandom_range(0, 7) != 0), 3'($urandom_range(0, 7)),
           pick_opnd(), pick_opnd(), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 7) == 0), 4'($urandom_range(0, 15)));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule